// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a test access port for boundary scan with a four-bit instruction register. A sixteen-state controller runs on the test clock. It is steered by the mode-select input `tms` and can also be forced to its reset state by a synchronous active-high `rst`. Depending on the current instruction, serial data entering on `tdi` passes through one of three registers before it leaves on `tdo`: a one-bit bypass stage, a 32-bit identification word, or a boundary register that holds two cells per covered pin.

The boundary register holds one data cell and one enable cell for each pin. Each cell has a shift stage and an update stage. The shift stage captures the pad input values and the core's output enables. It then shifts towards `tdo`. The update stage is loaded from the shift stage only at Update-DR, and only the update stage can drive the pads. A per-pin multiplexer chooses between three sources for each pad: the core's own value and enable, the update stage, or a forced high-impedance enable. Under the freezing instructions, both stages of the boundary register keep their contents while the bypass stage carries the scan path.

Top module: `jtag_bscan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state test access port graph on rising `tck`. Five rising edges with `tms` high reach Test-Logic-Reset from any state, and `rst` high at a rising edge forces Test-Logic-Reset.
- R2: While in Test-Logic-Reset, the active instruction becomes IDCODE (binary 1110) at the falling edge. After reset, `tdo_oe` is 0 and every pad follows `core_out` and `core_oe`.
- R3: Capture-IR loads binary 0001 into the instruction shift stage. Shift-IR shifts `tdi` into bit 3 and presents bit 0 on `tdo`. The new instruction takes effect at the falling edge of `tck` in Update-IR.
- R4: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only in Shift-DR or Shift-IR. In every other state `tdo` and `tdo_oe` are both 0.
- R5: Under IDCODE, Capture-DR loads the 32-bit identity word, whose bit 0 is always 1. Shift-DR then sends the word out least significant bit first. The pads keep their functional paths.
- R6: Under BYPASS (binary 1111), and under any code other than 0000, 0001, 0010, 0011 and 1110, a one-bit stage captures 0 and delays `tdi` by one shift before it reaches `tdo`.
- R7: Under SAMPLE/PRELOAD (binary 0001), Capture-DR loads `pin_in` into boundary bits [N-1:0] and `core_oe` into bits [2N-1:N]. Shifting moves bit 0 to `tdo` and `tdi` into bit 2N-1. The pads keep their functional paths.
- R8: At the falling edge in Update-DR, with the boundary register selected, the shift stage is copied to the update stage. Under EXTEST (binary 0000), `pad_out[i]` equals update bit i and `pad_oe[i]` equals update bit N+i.
- R9: Under CLAMP (binary 0010), the pads are driven from the update stage as under EXTEST, and the scan path is the one-bit bypass stage.
- R10: Under HIGHZ (binary 0011), every `pad_oe` bit is 0 and `pad_out` follows `core_out`. The scan path is the one-bit bypass stage.
- R11: While CLAMP or HIGHZ is active, neither stage of the boundary register changes, whatever the sequence of controller states.
- R12: Under EXTEST, the pads do not change during Capture-DR or Shift-DR. They change only at the following Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset to Test-Logic-Reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| core_out | input | NPINS | Functional output values from the core |
| core_oe | input | NPINS | Functional output enables from the core |
| pin_in | input | NPINS | Values present at the pads |
| pad_out | output | NPINS | Output value sent to each pad |
| pad_oe | output | NPINS | Output enable sent to each pad |

## Verification
The controller state and all shift stages move on a rising edge of `tck`. The next falling edge then updates `tdo` and `tdo_oe`, loads a new instruction, and loads the boundary update stage. The pad outputs follow combinationally from the instruction and the update stage. Every result is therefore due in the same clock, one half-period after the rising edge that consumed the stimulus. The bench drives each `tms`/`tdi` pair just after a falling edge and samples all outputs 1 ns after the next falling edge. It compares them there with a behavioural model that advances one step per clock. Scan results are gathered bit by bit from these samples, so a shift that arrives a cycle late or early shows up as a wrong word.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = 4'b0000;
    localparam opcode_t OP_SAMPLE  = 4'b0001;
    localparam opcode_t OP_CLAMP   = 4'b0010;
    localparam opcode_t OP_HIGHZ   = 4'b0011;
    localparam opcode_t OP_IDCODE  = 4'b1110;
    localparam opcode_t OP_BYPASS  = 4'b1111;
    localparam opcode_t IR_CAPTURE = 4'b0001;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_BOUNDARY} dr_sel_e;
    typedef enum logic [1:0] {PIN_FUNC, PIN_SCAN, PIN_FLOAT} pin_mode_e;

    typedef struct packed {
        dr_sel_e   dr;
        pin_mode_e pins;
    } decode_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            TS_RESET:  n = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  n = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: n = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  n = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: n = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = tms ? TS_UPD_IR : TS_SH_IR;
            default:   n = tms ? TS_SEL_DR : TS_IDLE;
        endcase
        return n;
    endfunction

    function automatic decode_t op_decode(opcode_t op);
        decode_t d;
        case (op)
            OP_EXTEST: d = '{dr: DR_BOUNDARY, pins: PIN_SCAN};
            OP_SAMPLE: d = '{dr: DR_BOUNDARY, pins: PIN_FUNC};
            OP_CLAMP:  d = '{dr: DR_BYPASS,   pins: PIN_SCAN};
            OP_HIGHZ:  d = '{dr: DR_BYPASS,   pins: PIN_FLOAT};
            OP_IDCODE: d = '{dr: DR_IDCODE,   pins: PIN_FUNC};
            default:   d = '{dr: DR_BYPASS,   pins: PIN_FUNC};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

endmodule

// File: rtl/jtag_instr_reg.sv
module jtag_instr_reg
    import jtag_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output opcode_t    ir_sr,
    output opcode_t    ir
);

    always_ff @(posedge tck) begin
        if (rst)                      ir_sr <= '0;
        else if (state == TS_CAP_IR)  ir_sr <= IR_CAPTURE;
        else if (state == TS_SH_IR)   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst || state == TS_RESET) ir <= OP_IDCODE;
        else if (state == TS_UPD_IR)  ir <= ir_sr;
    end

endmodule

// File: rtl/jtag_bsr.sv
module jtag_bsr
    import jtag_bscan_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               cap_en,
    input  logic               sh_en,
    input  logic               upd_en,
    input  logic               tdi,
    input  pin_mode_e          mode,
    input  logic [NPINS-1:0]   pin_in,
    input  logic [NPINS-1:0]   core_out,
    input  logic [NPINS-1:0]   core_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [2*NPINS-1:0] sr_q,
    output logic [2*NPINS-1:0] upd_q
);

    localparam int LEN = 2 * NPINS;

    always_ff @(posedge tck) begin
        if (rst)         sr_q <= '0;
        else if (cap_en) sr_q <= {core_oe, pin_in};
        else if (sh_en)  sr_q <= {tdi, sr_q[LEN-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst)         upd_q <= '0;
        else if (upd_en) upd_q <= sr_q;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_comb begin
            case (mode)
                PIN_SCAN: begin
                    pad_out[i] = upd_q[i];
                    pad_oe[i]  = upd_q[NPINS+i];
                end
                PIN_FLOAT: begin
                    pad_out[i] = core_out[i];
                    pad_oe[i]  = 1'b0;
                end
                default: begin
                    pad_out[i] = core_out[i];
                    pad_oe[i]  = core_oe[i];
                end
            endcase
        end
    end

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
    import jtag_bscan_pkg::*;
#(
    parameter int          NPINS    = 4,
    parameter logic [31:0] ID_VALUE = 32'h0BA5_E0A3
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] core_oe,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

    tap_state_e          state;
    opcode_t             ir;
    opcode_t             ir_sr;
    decode_t             dec;
    logic                bypass_q;
    logic [ID_W-1:0]     id_sr;
    logic [2*NPINS-1:0]  bsr_sr;
    logic [2*NPINS-1:0]  bsr_upd;
    logic                bsr_cap, bsr_sh, bsr_upd_en;
    logic                dr_bit;

    jtag_tap_fsm u_fsm (
        .tck(tck), .rst(rst), .tms(tms), .state(state)
    );

    jtag_instr_reg u_ir (
        .tck(tck), .rst(rst), .state(state), .tdi(tdi), .ir_sr(ir_sr), .ir(ir)
    );

    assign dec        = op_decode(ir);
    assign bsr_cap    = (state == TS_CAP_DR) && (dec.dr == DR_BOUNDARY);
    assign bsr_sh     = (state == TS_SH_DR)  && (dec.dr == DR_BOUNDARY);
    assign bsr_upd_en = (state == TS_UPD_DR) && (dec.dr == DR_BOUNDARY);

    jtag_bsr #(.NPINS(NPINS)) u_bsr (
        .tck(tck), .rst(rst),
        .cap_en(bsr_cap), .sh_en(bsr_sh), .upd_en(bsr_upd_en),
        .tdi(tdi), .mode(dec.pins),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .sr_q(bsr_sr), .upd_q(bsr_upd)
    );

    always_ff @(posedge tck) begin
        if (rst) begin
            bypass_q <= 1'b0;
            id_sr    <= '0;
        end else if (state == TS_CAP_DR) begin
            if (dec.dr == DR_BYPASS) bypass_q <= 1'b0;
            if (dec.dr == DR_IDCODE) id_sr    <= ID_WORD;
        end else if (state == TS_SH_DR) begin
            if (dec.dr == DR_BYPASS) bypass_q <= tdi;
            if (dec.dr == DR_IDCODE) id_sr    <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    always_comb begin
        case (dec.dr)
            DR_IDCODE:   dr_bit = id_sr[0];
            DR_BOUNDARY: dr_bit = bsr_sr[0];
            default:     dr_bit = bypass_q;
        endcase
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (state == TS_SH_DR) begin
            tdo    <= dr_bit;
            tdo_oe <= 1'b1;
        end else if (state == TS_SH_IR) begin
            tdo    <= ir_sr[0];
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/jtag_bscan_checker.sv
module jtag_bscan_checker
    import jtag_bscan_pkg::*;
#(
    parameter int NPINS = 4
) (
    input logic               tck,
    input logic               rst,
    input tap_state_e         state,
    input opcode_t            ir,
    input opcode_t            ir_sr,
    input logic [2*NPINS-1:0] bsr_sr,
    input logic [2*NPINS-1:0] bsr_upd,
    input logic               tdo_oe,
    input logic [NPINS-1:0]   pad_out,
    input logic [NPINS-1:0]   pad_oe
);

    assert_tlr_loads_idcode_R2: assert property (@(posedge tck) disable iff (rst)
        (state == TS_RESET) |=> (ir == OP_IDCODE));

    assert_capture_ir_pattern_R3: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));

    assert_tdo_oe_only_shift_R4: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (state == TS_SH_DR || state == TS_SH_IR));

    assert_clamp_drives_update_R9: assert property (@(posedge tck) disable iff (rst)
        (ir == OP_CLAMP) |-> (pad_out == bsr_upd[NPINS-1:0] && pad_oe == bsr_upd[2*NPINS-1:NPINS]));

    assert_highz_floats_R10: assert property (@(posedge tck) disable iff (rst)
        (ir == OP_HIGHZ) |-> (pad_oe == '0));

    assert_frozen_boundary_R11: assert property (@(posedge tck) disable iff (rst)
        (ir == OP_CLAMP || ir == OP_HIGHZ) |=> ($stable(bsr_sr) && $stable(bsr_upd)));

endmodule

bind jtag_bscan_tap jtag_bscan_checker #(.NPINS(NPINS)) u_checker (
    .tck(tck), .rst(rst), .state(state), .ir(ir), .ir_sr(ir_sr),
    .bsr_sr(bsr_sr), .bsr_upd(bsr_upd), .tdo_oe(tdo_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_jtag_bscan_tap.sv
module test_jtag_bscan_tap;

    localparam int NP = 4;
    localparam int BW = 2 * NP;
    localparam logic [31:0] IDV = 32'h0BA5_E0A3;

    logic tck = 1'b0;
    logic rst, tms, tdi;
    logic tdo, tdo_oe;
    logic [NP-1:0] core_out, core_oe, pin_in, pad_out, pad_oe;

    always #2.5 tck = ~tck;

    jtag_bscan_tap #(.NPINS(NP), .ID_VALUE(IDV)) i_jtag_bscan_tap (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string tag = "R2";

    // behavioural reference: states 0..15 = reset, idle, DR column (2..8), IR column (9..15)
    int m_st;
    logic [3:0] m_ir, m_irsr;
    logic m_bp, m_tdo, m_oe;
    logic [31:0] m_id;
    logic [BW-1:0] m_bsr, m_upd;

    function automatic int nxt(int s, logic t);
        case (s)
            0: return t ? 0 : 1;
            1: return t ? 2 : 1;
            2: return t ? 9 : 3;
            3, 4: return t ? 5 : 4;
            5: return t ? 8 : 6;
            6: return t ? 7 : 6;
            7: return t ? 8 : 4;
            8, 15: return t ? 2 : 1;
            9: return t ? 0 : 10;
            10, 11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            default: return t ? 15 : 11;
        endcase
    endfunction

    // 0 bypass, 1 identity word, 2 boundary
    function automatic int path(logic [3:0] op);
        if (op == 4'b0000 || op == 4'b0001) return 2;
        if (op == 4'b1110) return 1;
        return 0;
    endfunction

    task automatic model_rise(logic r, logic t, logic d);
        if (r) begin
            m_st = 0; m_irsr = 0; m_bp = 0; m_id = 0; m_bsr = 0;
        end else begin
            if (m_st == 10) m_irsr = 4'b0001;
            if (m_st == 11) m_irsr = {d, m_irsr[3:1]};
            if (m_st == 3) begin
                if (path(m_ir) == 0) m_bp = 0;
                if (path(m_ir) == 1) m_id = IDV;
                if (path(m_ir) == 2) m_bsr = {core_oe, pin_in};
            end
            if (m_st == 4) begin
                if (path(m_ir) == 0) m_bp = d;
                if (path(m_ir) == 1) m_id = {d, m_id[31:1]};
                if (path(m_ir) == 2) m_bsr = {d, m_bsr[BW-1:1]};
            end
            m_st = nxt(m_st, t);
        end
    endtask

    task automatic model_fall(logic r);
        if (r) begin
            m_ir = 4'b1110; m_upd = 0; m_tdo = 0; m_oe = 0;
        end else begin
            m_oe = 1'b1;
            if (m_st == 4)
                m_tdo = (path(m_ir) == 0) ? m_bp : (path(m_ir) == 1) ? m_id[0] : m_bsr[0];
            else if (m_st == 11)
                m_tdo = m_irsr[0];
            else begin
                m_tdo = 0; m_oe = 0;
            end
            if (m_st == 0) m_ir = 4'b1110;
            if (m_st == 15) m_ir = m_irsr;
            if (m_st == 8 && path(m_ir) == 2) m_upd = m_bsr;
        end
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic [NP-1:0] eo, ee;
        if (m_ir == 4'b0000 || m_ir == 4'b0010) begin
            eo = m_upd[NP-1:0]; ee = m_upd[BW-1:NP];
        end else if (m_ir == 4'b0011) begin
            eo = core_out; ee = '0;
        end else begin
            eo = core_out; ee = core_oe;
        end
        check(tag, {50'd0, tdo, tdo_oe, pad_out, pad_oe}, {50'd0, m_tdo, m_oe, eo, ee});
    endtask

    task automatic tick(logic t, logic d);
        logic r;
        r = rst;
        tms = t; tdi = d;
        @(posedge tck);
        model_rise(r, t, d);
        @(negedge tck);
        model_fall(r);
        #1;
        compare_model();
    endtask

    task automatic ir_scan(logic [3:0] code, output logic [3:0] captured);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            captured[i] = tdo;
            tick(i == 3, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic dr_scan(int n, logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] cap;
        logic [63:0] so;
        rst = 1; tms = 1; tdi = 0;
        core_out = 4'h9; core_oe = 4'h6; pin_in = 4'hA;
        #1;
        tag = "R2";
        repeat (3) tick(1, 0);
        rst = 0;
        tick(1, 0);
        check("R2", {60'd0, pad_out}, {60'd0, core_out});
        check("R2", {63'd0, tdo_oe}, 64'd0);
        tick(0, 0);

        tag = "R5";
        dr_scan(32, 64'd0, so);
        check("R5", so, {32'd0, IDV});

        tag = "R6";
        ir_scan(4'b1111, cap);
        check("R3", {60'd0, cap}, 64'd1);
        dr_scan(8, 64'hB2, so);
        check("R6", so, 64'h64);
        ir_scan(4'b0101, cap);
        dr_scan(8, 64'h0F, so);
        check("R6", so, 64'h1E);

        tag = "R1";
        tick(1, 0); tick(0, 0); tick(0, 0);
        repeat (5) tick(1, 0);
        tick(0, 0);
        check("R4", {63'd0, tdo_oe}, 64'd0);
        dr_scan(32, 64'd0, so);
        check("R1", so, {32'd0, IDV});

        tag = "R7";
        pin_in = 4'hA; core_oe = 4'h5; core_out = 4'h3;
        ir_scan(4'b0001, cap);
        check("R3", {60'd0, cap}, 64'd1);
        dr_scan(8, 64'hC3, so);
        check("R7", so, 64'h5A);
        check("R7", {56'd0, pad_out, pad_oe}, {56'd0, core_out, core_oe});

        tag = "R8";
        ir_scan(4'b0000, cap);
        check("R8", {56'd0, pad_out, pad_oe}, 64'h3C);
        tag = "R12";
        dr_scan(8, 64'h96, so);
        check("R12", so, 64'h5A);
        check("R8", {56'd0, pad_out, pad_oe}, 64'h69);

        tag = "R9";
        ir_scan(4'b0010, cap);
        check("R9", {56'd0, pad_out, pad_oe}, 64'h69);
        dr_scan(8, 64'hFF, so);
        check("R9", so, 64'hFE);
        tag = "R11";
        ir_scan(4'b0000, cap);
        check("R11", {56'd0, pad_out, pad_oe}, 64'h69);

        tag = "R10";
        core_out = 4'hC;
        ir_scan(4'b0011, cap);
        check("R10", {56'd0, pad_out, pad_oe}, 64'hC0);
        dr_scan(8, 64'h55, so);
        check("R10", so, 64'hAA);
        tag = "R11";
        ir_scan(4'b0000, cap);
        check("R11", {56'd0, pad_out, pad_oe}, 64'h69);

        tag = "R1";
        tick(1, 0); tick(0, 0);
        rst = 1;
        tick(0, 0);
        rst = 0;
        tick(0, 0);
        check("R1", {56'd0, pad_out, pad_oe}, {56'd0, core_out, core_oe});
        tag = "R4";
        repeat (3) tick(0, 1);

        done = 1;
        summary();
        $finish;
    end

endmodule